// File: doc/BRIEF.md
# Microsecond Time Base Generator

This block derives a steady 1 MHz count from a reference clock that may run at any of several common rates. A fractional prescaler does the rate conversion. It adds a programmable step (the dividend) into an accumulator on every reference cycle. Each time the accumulator reaches the modulus (the divisor), it emits one tick and subtracts the modulus.

With this scheme a non-integer ratio still yields an exact average rate. For example, 19.2 MHz gives 5 ticks in every 96 reference cycles. Each tick advances a free-running up-counter, and a bus master reads that counter as elapsed microseconds.

Software reaches the block through a single-cycle register port. The port has an address, a write strobe, write data and combinational read data. Through it, software sets the prescaler ratio, reads the counter, and can freeze the time base. While frozen, both the counter and the prescaler phase hold.

Top module: `usec_timebase`

## Requirements
- R1: After reset the configuration register reads 0x0000000B, the counter reads 0 and the freeze register reads 0.
- R2: Register map, read combinationally in the same cycle the address is presented:
  - 0x10 is the counter, read-only.
  - 0x14 is the configuration, read/write, with bits 15:0 stored and upper bits reading 0.
  - 0x4C is the freeze control, with bit 0 stored and the rest reading 0.
  - Any other address reads 0.
- R3: Configuration bits [7:0] hold the divisor minus one and bits [15:8] hold the dividend minus one. When dividend ≤ divisor, the counter advances by exactly dividend counts in every window of divisor reference cycles.
- R4: With configuration 0x000B, the counter advances by exactly 10 in any 120 consecutive reference cycles.
- R5: With configuration 0x045F, the counter advances by exactly 5 in any 96 consecutive reference cycles.
- R6: While the freeze bit is 1, the counter holds its value and the accumulator does not advance. Clearing the bit resumes counting from the held phase.
- R7: A write to the counter address has no effect on the counter.
- R8: A write to the configuration register restarts the accumulator from zero at that clock edge.
- R9: The counter wraps from all ones to zero on the next tick, with no other indication.
- R10: When the dividend is greater than or equal to the divisor, the counter advances on every reference cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (8) | Register byte address |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |

## Verification
The wrap from all ones to zero is the hardest case to reach, because a full-width counter would need billions of ticks. The bench therefore builds the block with a 12-bit counter and programs a 1:1 ratio, so the counter ticks every cycle and wraps within a few thousand cycles. It then reads the counter on both sides of the wrap.

A scoreboard model tracks the accumulator phase across configuration writes and freeze intervals. This lets the bench predict every counter read exactly. Separate delta checks over fixed windows confirm the average rates independently of the phase.

// File: rtl/usec_pkg.sv
`timescale 1ns/1ps
package usec_pkg;
  localparam logic [7:0] ADDR_CNT = 8'h10;
  localparam logic [7:0] ADDR_CFG = 8'h14;
  localparam logic [7:0] ADDR_FRZ = 8'h4c;
  localparam logic [15:0] CFG_RESET = 16'h000b;
endpackage

// File: rtl/usec_regs.sv
`timescale 1ns/1ps
module usec_regs #(
  parameter int ADDR_W = 8,
  parameter int CFG_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              frz_o,
  output logic              cfg_wr_o
);
  import usec_pkg::*;

  logic frz_wr;
  assign cfg_wr_o = wr_en_i && (addr_i == ADDR_W'(ADDR_CFG));
  assign frz_wr   = wr_en_i && (addr_i == ADDR_W'(ADDR_FRZ));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= CFG_W'(CFG_RESET);
      frz_o <= 1'b0;
    end else begin
      if (cfg_wr_o) cfg_o <= wdata_i[CFG_W-1:0];
      if (frz_wr)   frz_o <= wdata_i[0];
    end
  end

  AST_CFG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_o |=> cfg_o == $past(wdata_i[CFG_W-1:0])); // R2
endmodule

// File: rtl/usec_frac_prescaler.sv
`timescale 1ns/1ps
module usec_frac_prescaler #(
  parameter int FRAC_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2*FRAC_W-1:0] cfg_i,
  input  logic                frz_i,
  input  logic                clr_i,
  output logic                tick_o
);
  localparam int ACC_W = FRAC_W + 1;

  logic [ACC_W-1:0] dvs, dvd, acc_q, acc_d;
  logic [ACC_W:0]   sum;
  logic             dvd_ge;

  assign dvs    = ACC_W'(cfg_i[FRAC_W-1:0]) + ACC_W'(1);
  assign dvd    = ACC_W'(cfg_i[2*FRAC_W-1:FRAC_W]) + ACC_W'(1);
  assign dvd_ge = dvd >= dvs;
  assign sum    = {1'b0, acc_q} + {1'b0, dvd};
  assign tick_o = !frz_i && (sum >= {1'b0, dvs});

  always_comb begin
    acc_d = acc_q;
    if (!frz_i) begin
      if (dvd_ge)      acc_d = '0;
      else if (tick_o) acc_d = ACC_W'(sum - {1'b0, dvs});
      else             acc_d = sum[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else            acc_q <= acc_d;
  end

  AST_ACC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < dvs || $past(clr_i) == 1'b0 && $changed(cfg_i)); // R3
  AST_CLR_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_q == '0); // R8
  AST_FRZ_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_i && !clr_i) |=> $stable(acc_q)); // R6
  AST_FAST_RATIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dvd_ge && !frz_i) |-> tick_o); // R10
endmodule

// File: rtl/usec_counter.sv
`timescale 1ns/1ps
module usec_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + CNT_W'(1);
  end

  AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (&cnt_o)) |=> cnt_o == '0); // R9
  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o)); // R3
endmodule

// File: rtl/usec_timebase.sv
`timescale 1ns/1ps
module usec_timebase #(
  parameter int ADDR_W = 8,
  parameter int FRAC_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  import usec_pkg::*;
  localparam int CFG_W = 2 * FRAC_W;

  logic [CFG_W-1:0] cfg;
  logic             frz, cfg_wr, tick;
  logic [CNT_W-1:0] cnt;

  usec_regs #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i,
    .cfg_o(cfg), .frz_o(frz), .cfg_wr_o(cfg_wr)
  );

  usec_frac_prescaler #(.FRAC_W(FRAC_W)) u_pre (
    .clk_i, .rst_ni, .cfg_i(cfg), .frz_i(frz), .clr_i(cfg_wr), .tick_o(tick)
  );

  usec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .cnt_o(cnt)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_CNT))      rdata_o = 32'(cnt);
    else if (addr_i == ADDR_W'(ADDR_CFG)) rdata_o = 32'(cfg);
    else if (addr_i == ADDR_W'(ADDR_FRZ)) rdata_o = {31'd0, frz};
  end

  AST_FRZ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz |=> $stable(cnt)); // R6
  AST_CNT_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(ADDR_CNT) && !tick) |=> $stable(cnt)); // R7
endmodule

// File: tb/usec_timebase_test.sv
`timescale 1ns/1ps
module usec_timebase_test;
  localparam int CW = 12;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0, rdata;
  int checks = 0, errors = 0;

  usec_timebase #(.CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata)
  );

  always #2.5 clk = ~clk;

  // Requirement model: ratio, freeze, accumulator restart, wrap
  logic [15:0] m_cfg = 16'h000b;
  logic        m_frz = 1'b0;
  int          m_acc = 0;
  int unsigned m_cnt = 0;
  always @(posedge clk) begin
    if (rst_n) begin
      int dvd, dvs, s;
      bit t;
      dvd = int'(m_cfg[15:8]) + 1;
      dvs = int'(m_cfg[7:0]) + 1;
      s = m_acc + dvd;
      t = !m_frz && s >= dvs;
      if (!m_frz) m_acc = (dvd >= dvs) ? 0 : (t ? s - dvs : s);
      if (t) m_cnt = (m_cnt + 1) & ((1 << CW) - 1);
      if (wr_en && addr == 8'h14) begin m_cfg = wdata[15:0]; m_acc = 0; end
      if (wr_en && addr == 8'h4c) m_frz = wdata[0];
    end
  end

  // Scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];
  always @(negedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      logic [31:0] e;
      string tg;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s actual %h expected %h", tg, rdata, e);
      end
    end
  end

  function automatic logic [31:0] expect_for(input logic [7:0] a);
    case (a)
      8'h10:   return m_cnt;
      8'h14:   return {16'd0, m_cfg};
      8'h4c:   return {31'd0, m_frz};
      default: return 32'd0;
    endcase
  endfunction

  task automatic rd(input logic [7:0] a, input string tg, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    exp_q.push_back(expect_for(a));
    tag_q.push_back(tg);
    #1 v = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 8'h10;
  endtask

  task automatic chk(input bit ok, input string tg, input int act, input int ex);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tg, act, ex);
    end
  endtask

  task automatic delta(input int win, input int ex, input string tg);
    logic [31:0] a, b;
    rd(8'h10, tg, a);
    repeat (win - 1) @(negedge clk);
    rd(8'h10, tg, b);
    chk(((b - a) & ((1 << CW) - 1)) == ex, tg, int'((b - a) & ((1 << CW) - 1)), ex);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(8'h14, "R1 cfg reset", v);
    rd(8'h10, "R1 cnt reset", v);
    rd(8'h4c, "R1 frz reset", v);
    rd(8'h20, "R2 unused addr", v);
    wr(8'h14, 32'hffff_000b);
    rd(8'h14, "R2 cfg upper bits", v);
    repeat (50) @(negedge clk);
    rd(8'h10, "R4 count 12MHz", v);
    delta(120, 10, "R4 window");
    wr(8'h10, 32'h0000_0abc);
    rd(8'h10, "R7 counter write ignored", v);
    wr(8'h14, 32'h0000_045f);
    rd(8'h10, "R8 restart", v);
    repeat (37) @(negedge clk);
    rd(8'h10, "R5 phase", v);
    delta(96, 5, "R5 window");
    delta(96, 5, "R5 window2");
    wr(8'h4c, 32'h1);
    rd(8'h4c, "R2 frz readback", v);
    rd(8'h10, "R6 frozen", p);
    repeat (30) @(negedge clk);
    rd(8'h10, "R6 frozen later", v);
    chk(v == p, "R6 hold", int'(v), int'(p));
    wr(8'h4c, 32'h0);
    repeat (23) @(negedge clk);
    rd(8'h10, "R6 resume", v);
    wr(8'h14, 32'h0000_0204);
    delta(50, 30, "R3 ratio 3/5");
    wr(8'h14, 32'h0000_0300);
    delta(20, 20, "R10 dividend above divisor");
    wr(8'h14, 32'h0000_0000);
    rd(8'h10, "R9 start", p);
    repeat ((1 << CW) - int'(p) - 4) @(negedge clk);
    for (int i = 0; i < 8; i++) rd(8'h10, "R9 near wrap", v);
    chk(v < 32'd8, "R9 wrapped", int'(v), 4);
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule